// File: doc/BRIEF.md
# Wrapping Burst-Mode Read Engine

This block is the read side of a 16-bit word memory that can be read in two ways. In the plain mode the word at the presented address is returned combinationally whenever both chip enable and output enable are low. The clock, the load strobe and the advance strobe have no effect in this mode. A single-cycle enable strobe switches the block into a synchronous burst mode. In burst mode a load strobe captures a start address. After a fixed initial latency, the block then steps through the 32 words of the aligned block that holds that address, wrapping inside it.

While bursting, the host can stop advancing and hold the current word, either with the outputs idle or with the word presented. It ends a burst in one of three ways, and each one leaves the block in its own mode. A disable strobe returns the block to the plain mode. Chip enable going high ends the burst but keeps burst mode. The reset pin ends everything and forces the plain mode. The storage is a small internal array that is filled through a dedicated write port.

Top module: `wrap_burst_reader`

## Requirements
- R1: While `rst_n` is low the block is in plain mode: `rd_valid` equals (ce_n==0 and oe_n==0), `rd_data` is the word at `addr`, and `last_n` is 1.
- R2: In plain mode, `rd_valid` is 1 exactly when `ce_n` and `oe_n` are both 0, and `rd_data` is then the stored word at `addr`. `load_n`, `adv_n` and clock edges have no effect on the outputs.
- R3: A clock edge with `burst_on` high (and `burst_off` low) enters burst mode. A clock edge with `burst_off` high stops any burst and returns to plain mode. `burst_off` wins when both are high.
- R4: In burst mode, an edge with `ce_n`=0 and `load_n`=0 captures `addr` as the start and clears the 5-bit count. `rd_valid` then stays 0 until LATENCY further edges (default 3) have passed with `ce_n` low. After that the start word is presented.
- R5: Once the first word is valid, each edge with `ce_n`, `oe_n` and `adv_n` all 0 increments the count. The presented word is at address {start[ADDR_W-1:5], (start[4:0]+count) mod 32}.
- R6: The word order wraps inside the aligned 32-word block. For example, start offset 2 gives 2,3,…,31,0,1 and start offset 8 gives 8,…,31,0,…,7.
- R7: `last_n` is 0 exactly while the 32nd word of the sequence (count 31) is presented. The next advance presents the start word again.
- R8: With `oe_n`=1, `rd_valid` is 0 and the count and start are held. An edge with `oe_n`=1 never advances, whatever `adv_n` is.
- R9: With `oe_n`=0 and `adv_n`=1, the held word is presented and stays unchanged for as long as `adv_n` stays high.
- R10: An edge with `ce_n`=1 ends the burst while keeping burst mode. No word is valid until a new load, which starts at the address present then.
- R11: `rst_n` going low ends any burst at once, without waiting for a clock, and forces plain mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| load_n | input | 1 | Load start address, active low |
| adv_n | input | 1 | Advance burst, active low |
| addr | input | ADDR_W | Word address |
| burst_on | input | 1 | Enter burst mode strobe |
| burst_off | input | 1 | Leave burst mode strobe |
| wr_en | input | 1 | Preload write enable |
| wr_addr | input | ADDR_W | Preload write address |
| wr_data | input | DATA_W | Preload write data |
| rd_data | output | DATA_W | Read word, zero when not valid |
| rd_valid | output | 1 | Output driven flag |
| last_n | output | 1 | Active-low last-word-of-burst indicator |

## Verification
Bursts are started at offset 2 and offset 8 and run past 32 words. This shows a correct modulo-32 wrap inside the aligned block apart from a linear count that spills into the next block, and shows that the end marker falls on the 32nd word and not on offset 31. Suspend with outputs idle, hold with the word shown, and advance attempts with output enable high each separate counter holding from counter stepping. Chip-enable ends, disable strobes and a mid-burst reset are each followed by reads that tell apart the mode that remains. A long seeded random mix of all the strobes is then compared cycle by cycle against a bench model.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
   typedef enum logic {
      MODE_PLAIN = 1'b0,
      MODE_BURST = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/wbr_array.sv
module wbr_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
   end

   assign rd_data = store[rd_addr];
endmodule

// File: rtl/wbr_mode_ctl.sv
module wbr_mode_ctl
   import wbr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     burst_on,
   input  logic     burst_off,
   output rd_mode_e mode
);
   rd_mode_e mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mode_q <= MODE_PLAIN;
      else if (burst_off) mode_q <= MODE_PLAIN;
      else if (burst_on)  mode_q <= MODE_BURST;
   end

   assign mode = mode_q;

   AST_OFF_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
      burst_off |=> mode == MODE_PLAIN); // R3
   AST_ON_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_on && !burst_off) |=> mode == MODE_BURST); // R3
endmodule

// File: rtl/wbr_burst_seq.sv
module wbr_burst_seq
   import wbr_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int OFF_W   = 5,
   parameter int LATENCY = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rd_mode_e          mode,
   input  logic              burst_off,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              load_n,
   input  logic              adv_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              ready,
   output logic [OFF_W-1:0]  count,
   output logic [ADDR_W-1:0] start
);
   localparam int LAT_W = $clog2(LATENCY + 1);
   localparam logic [LAT_W-1:0] LAT_LOAD = LAT_W'(LATENCY);

   logic              active_q;
   logic [LAT_W-1:0]  lat_q;
   logic [OFF_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] start_q;
   logic              in_burst;
   logic              do_load;
   logic              do_step;

   assign in_burst = (mode == MODE_BURST) && !burst_off;
   assign do_load  = in_burst && !ce_n && !load_n;
   assign do_step  = in_burst && !ce_n && load_n && active_q &&
                     (lat_q == '0) && !oe_n && !adv_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         lat_q    <= '0;
         cnt_q    <= '0;
         start_q  <= '0;
      end else if (!in_burst || ce_n) begin
         active_q <= 1'b0;
         lat_q    <= '0;
      end else if (do_load) begin
         active_q <= 1'b1;
         lat_q    <= LAT_LOAD;
         cnt_q    <= '0;
         start_q  <= addr;
      end else if (active_q && lat_q != '0) begin
         lat_q <= lat_q - 1'b1;
      end else if (do_step) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ready = active_q && (lat_q == '0);
   assign count = cnt_q;
   assign start = start_q;

   AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      do_load |=> (cnt_q == '0) && active_q && !ready); // R4
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      do_step |=> cnt_q == OFF_W'($past(cnt_q) + 1'b1)); // R5
   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_burst && !ce_n && load_n && active_q && (oe_n || adv_n))
         |=> $stable(cnt_q) && $stable(start_q)); // R8
   AST_CE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n && mode == MODE_BURST) |=> !ready); // R10
endmodule

// File: rtl/wbr_addr_gen.sv
module wbr_addr_gen
   import wbr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int OFF_W  = 5
) (
   input  rd_mode_e          mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] start,
   input  logic [OFF_W-1:0]  count,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              last
);
   logic [OFF_W-1:0]  offset;
   logic [ADDR_W-1:0] burst_addr;

   assign offset = start[OFF_W-1:0] + count;

   generate
      if (ADDR_W == OFF_W) begin : g_single_block
         assign burst_addr = offset;
      end else begin : g_multi_block
         assign burst_addr = {start[ADDR_W-1:OFF_W], offset};
      end
   endgenerate

   assign rd_addr = (mode == MODE_BURST) ? burst_addr : addr;
   assign last    = &count;
endmodule

// File: rtl/wrap_burst_reader.sv
module wrap_burst_reader
   import wbr_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 16,
   parameter int OFF_W   = 5,
   parameter int LATENCY = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              load_n,
   input  logic              adv_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              burst_on,
   input  logic              burst_off,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              last_n
);
   generate
      if (OFF_W < 1 || OFF_W > ADDR_W) begin : g_bad_off
         $error("OFF_W must lie in 1..ADDR_W");
      end
      if (LATENCY < 1) begin : g_bad_lat
         $error("LATENCY must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   rd_mode_e          mode;
   logic              ready;
   logic [OFF_W-1:0]  count;
   logic [ADDR_W-1:0] start;
   logic [ADDR_W-1:0] rd_addr;
   logic              last;
   logic [DATA_W-1:0] word;
   logic              shown;

   wbr_mode_ctl u_mode (
      .clk(clk), .rst_n(rst_n), .burst_on(burst_on),
      .burst_off(burst_off), .mode(mode));

   wbr_burst_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LATENCY(LATENCY)) u_seq (
      .clk(clk), .rst_n(rst_n), .mode(mode), .burst_off(burst_off),
      .ce_n(ce_n), .oe_n(oe_n), .load_n(load_n), .adv_n(adv_n),
      .addr(addr), .ready(ready), .count(count), .start(start));

   wbr_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
      .mode(mode), .addr(addr), .start(start), .count(count),
      .rd_addr(rd_addr), .last(last));

   wbr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(word));

   assign shown    = !ce_n && !oe_n && ((mode == MODE_PLAIN) || ready);
   assign rd_valid = shown;
   assign rd_data  = shown ? word : '0;
   assign last_n   = !((mode == MODE_BURST) && ready && last);

   AST_VALID_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (!ce_n && !oe_n)); // R2
   AST_LAST_BURST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !last_n |-> (mode == MODE_BURST)); // R7
endmodule

// File: tb/wrap_burst_reader_test.sv
module wrap_burst_reader_test;
   localparam int AW  = 8;
   localparam int DW  = 16;
   localparam int LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, load_n = 1'b1, adv_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic burst_on = 1'b0, burst_off = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic rd_valid, last_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model state
   bit m_burst = 0, m_act = 0;
   logic [AW-1:0] m_start = '0;
   logic [4:0] m_cnt = '0;
   int m_lat = 0;

   always #5 clk = ~clk;

   wrap_burst_reader uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .load_n(load_n),
      .adv_n(adv_n), .addr(addr), .burst_on(burst_on), .burst_off(burst_off),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_data(rd_data), .rd_valid(rd_valid), .last_n(last_n));

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return DW'((32'(a) * 32'd40503) ^ 32'h0000A5C3);
   endfunction

   function automatic logic [AW-1:0] burst_word(input logic [AW-1:0] s,
                                                input logic [4:0] c);
      logic [4:0] o;
      o = s[4:0] + c;
      return {s[AW-1:5], o};
   endfunction

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // compare all outputs against the model; inputs already driven
   task automatic compare(input string req);
      bit ev;
      bit el;
      logic [AW-1:0] ea;
      if (!m_burst) begin
         ev = !ce_n && !oe_n;
         ea = addr;
         el = 1'b1;
      end else begin
         ev = !ce_n && !oe_n && m_act && (m_lat == 0);
         ea = burst_word(m_start, m_cnt);
         el = !(m_act && m_lat == 0 && m_cnt == 5'd31);
      end
      chk({req, " valid"}, 32'(rd_valid), 32'(ev));
      if (ev) chk({req, " data"}, 32'(rd_data), 32'(pat(ea)));
      chk("R7 last_n", 32'(last_n), 32'(el));
   endtask

   task automatic model_edge();
      if (burst_off) begin
         m_burst = 0; m_act = 0;
      end else if (!m_burst) begin
         if (burst_on) m_burst = 1;
         m_act = 0;
      end else if (ce_n) begin
         m_act = 0; m_lat = 0;
      end else if (!load_n) begin
         m_act = 1; m_start = addr; m_cnt = '0; m_lat = LAT;
      end else if (m_act && m_lat != 0) begin
         m_lat--;
      end else if (m_act && !oe_n && !adv_n) begin
         m_cnt++;
      end
   endtask

   // called at a negative edge: drive, check, then let the edge pass
   task automatic tick(input string req, input bit c, input bit o,
                       input bit l, input bit v, input logic [AW-1:0] a,
                       input bit on = 0, input bit off = 0);
      ce_n = c; oe_n = o; load_n = l; adv_n = v; addr = a;
      burst_on = on; burst_off = off;
      #2;
      compare(req);
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] held;
      void'($urandom(32'd1357));
      // preload while in reset
      @(negedge clk);
      for (int i = 0; i < (1 << AW); i++) begin
         wr_en = 1'b1; wr_addr = AW'(i); wr_data = pat(AW'(i));
         @(negedge clk);
      end
      wr_en = 1'b0;
      // R1: reset state, plain read works
      ce_n = 0; oe_n = 0; addr = 8'h15; load_n = 0; adv_n = 0; burst_on = 1;
      #2;
      chk("R1 valid", 32'(rd_valid), 32'd1);
      chk("R1 data", 32'(rd_data), 32'(pat(8'h15)));
      chk("R1 last_n", 32'(last_n), 32'd1);
      burst_on = 0;
      @(negedge clk);
      rst_n = 1'b1;
      // R2: plain mode ignores load/advance
      tick("R2", 0, 0, 0, 0, 8'h33);
      tick("R2", 0, 0, 1, 0, 8'h34);
      tick("R2", 0, 1, 0, 1, 8'h35);
      tick("R2", 1, 0, 0, 0, 8'h36);
      tick("R2", 0, 0, 1, 1, 8'hF0);
      // R3: enter burst mode
      tick("R3", 1, 1, 1, 1, 8'h00, 1, 0);
      chk("R3 mode", 32'(m_burst), 32'd1);
      // R4: load at offset 2, latency
      tick("R4", 0, 0, 0, 0, 8'h42);
      for (int i = 0; i < LAT; i++) tick("R4", 0, 0, 1, 0, 8'h00);
      // R6: 34 words, wraps inside block 0x40
      for (int i = 0; i < 34; i++) begin
         if (i == 29) chk("R7 before last", 32'(m_cnt), 32'd29);
         tick("R6", 0, 0, 1, 0, 8'h99);
      end
      // R8: suspend, outputs idle
      for (int i = 0; i < 3; i++) tick("R8", 0, 1, 1, 1, 8'h00);
      // R8: oe high, adv low does not advance
      tick("R8", 0, 1, 1, 0, 8'h00);
      // R9: held word shown
      held = burst_word(m_start, m_cnt);
      for (int i = 0; i < 3; i++) begin
         ce_n = 0; oe_n = 0; load_n = 1; adv_n = 1; #2;
         chk("R9 held", 32'(rd_data), 32'(pat(held)));
         tick("R9", 0, 0, 1, 1, 8'h00);
      end
      // R5: resume
      tick("R5", 0, 0, 1, 0, 8'h00);
      tick("R5", 0, 0, 1, 0, 8'h00);
      // R10: ce high ends burst, mode kept
      tick("R10", 1, 0, 1, 0, 8'h00);
      tick("R10", 0, 0, 1, 0, 8'h77);
      chk("R10 mode kept", 32'(m_burst), 32'd1);
      ce_n = 0; oe_n = 0; #2;
      chk("R10 no word", 32'(rd_valid), 32'd0);
      @(negedge clk);
      // R6: new burst at offset 8, run 40 words
      tick("R10", 0, 0, 0, 0, 8'h88);
      for (int i = 0; i < LAT; i++) tick("R4", 0, 0, 1, 0, 8'h00);
      for (int i = 0; i < 40; i++) tick("R6", 0, 0, 1, 0, 8'h00);
      // R3: disable returns to plain mode, off wins over on
      tick("R3", 0, 0, 1, 0, 8'h00, 1, 1);
      tick("R3", 0, 0, 0, 0, 8'h5C);
      chk("R3 plain data", 32'(m_burst), 32'd0);
      // R11: reset mid-burst
      tick("R11", 1, 1, 1, 1, 8'h00, 1, 0);
      tick("R11", 0, 0, 0, 0, 8'hC4);
      for (int i = 0; i < LAT + 4; i++) tick("R11", 0, 0, 1, 0, 8'h00);
      addr = 8'h0B; ce_n = 0; oe_n = 0; #1;
      rst_n = 0; #1;
      chk("R11 valid", 32'(rd_valid), 32'd1);
      chk("R11 data", 32'(rd_data), 32'(pat(8'h0B)));
      chk("R11 last_n", 32'(last_n), 32'd1);
      m_burst = 0; m_act = 0; m_cnt = '0; m_lat = 0; m_start = '0;
      @(negedge clk);
      rst_n = 1;
      // R5: seeded random mix
      for (int i = 0; i < 4000; i++) begin
         bit c, o, l, v, on, off;
         c   = ($urandom % 100) < 5;
         o   = ($urandom % 100) < 20;
         l   = ($urandom % 100) >= 6;
         v   = ($urandom % 100) < 25;
         on  = ($urandom % 100) < 3;
         off = ($urandom % 1000) < 4;
         tick("R5", c, o, l, v, AW'($urandom), on, off);
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule